// File: doc/BRIEF.md
# I2C Target Front End for an 8-Bit Input/Output Expander

This block is the serial side of a small expander. It watches a two-wire I2C bus and answers one device address. The upper six bits of that address are fixed at 010000, and the lowest bit comes from a strap pin. A write transfer sets a register pointer and can store data bytes. A read transfer, usually reached through a repeated START, returns the selected register one byte after another. The pointer is kept between transfers, so a controller that has selected the input port once can send a bare read address to stream fresh port samples.

Both bus lines are brought into the system clock domain, and the block takes START, STOP and bit timing from the oversampled levels. It drives SDA only through an open-drain enable, and it changes that enable while SCL is low. An 8-bit input port is synchronized and compared with the value the bus last read from it. Any difference pulls the active-low interrupt down. The interrupt goes high again as soon as the port byte is taken for transmission, without waiting for a STOP.

Top module: `gpio_i2c_target`

## Requirements
- R1: After reset, sda_oe_o is 0 and int_no is 1 while port_i is 0x00.
- R2: The target acknowledges an address byte {addr[6:0], rw} when addr[6:1] is 010000 and addr[0] equals addr_strap_i. ACK means sda_oe_o is 1 during the ninth SCL high period.
- R3: An address byte that does not match gets no ACK. All bytes after it are neither acknowledged nor written, until the next START.
- R4: After a write address, the target acknowledges the first byte for any value and stores it as the pointer, which holds across transfers. Each later byte is acknowledged and written to the register the pointer selects, and the pointer does not advance. Writes are kept only for pointers 1 to 3. Writes to pointer 0 or to a pointer above 3 are acknowledged and discarded.
- R5: After a read address, the target sends the selected register MSB first, driving a 0 bit by setting sda_oe_o. Pointer 0 returns the synchronized port_i, sampled at the SCL falling edge that starts each byte. Pointers 1 to 3 return their stored value, and any other pointer returns 0x00.
- R6: During a read, a controller ACK (SDA low in the ninth bit) makes the target send another byte. A NACK makes it release SDA until the next START or STOP, so further clocked bits read as 1.
- R7: int_no is 0 while the synchronized port_i differs from the value last loaded from pointer 0 for transmission. int_no returns to 1 when that load happens, before any STOP.
- R8: A START or repeated START at any point, including the middle of a byte, restarts address reception with the bit count cleared. A STOP at any point returns the target to idle. Bytes that were already acknowledged are kept, and a partial byte is discarded.
- R9: sda_oe_o changes only in the cycle after the synchronized SCL was seen low, or after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap_i | input | 1 | Strap giving bit 0 of the device address |
| port_i | input | 8 | Input port pins |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| int_no | output | 1 | Interrupt, active low |

## Verification
The bench uses the default parameters: four registers and two synchronizer stages, with a bus quarter-bit of 25 system clocks. Because four registers exist, random pointers from 0 to 7 cover the input port, the three stored registers and the empty addresses that read as zero. Changing the port during the controller's ACK phase checks that each streamed byte is sampled at its own starting falling edge. The two-stage delay leaves room for a START in the middle of a byte and a STOP partway through a data byte.

// File: rtl/gpio_i2c_pkg.sv
package gpio_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } st_e;
endpackage

// File: rtl/gpio_i2c_sync.sv
module gpio_i2c_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gpio_i2c_bus_cond.sv
module gpio_i2c_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] lines_s;
  logic       scl_p, sda_p;

  gpio_i2c_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  assign scl_o = lines_s[1];
  assign sda_o = lines_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_o;
      sda_p <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // data edges while the clock stays high
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/gpio_i2c_regs.sv
module gpio_i2c_regs #(
  parameter int DW          = 8,
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] port_i,
  input  logic [7:0]    ptr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_in_i,
  output logic [DW-1:0] rdata_o,
  output logic          int_no
);
  logic [DW-1:0] port_s, last_q;
  logic [DW-1:0] store_q [NUM_REGS];
  logic          int_q;

  gpio_i2c_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_port_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (port_s)
  );

  assign store_q[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_store
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     store_q[g] <= '0;
      else if (wr_i && ptr_i == 8'(g)) store_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ptr_i == 8'd0) rdata_o = port_s;
    for (int i = 1; i < NUM_REGS; i++)
      if (ptr_i == 8'(i)) rdata_o = store_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      int_q  <= 1'b0;
    end else if (rd_in_i) begin
      last_q <= port_s;
      int_q  <= 1'b0;
    end else begin
      int_q  <= port_s != last_q;
    end
  end

  assign int_no = ~int_q;
endmodule

// File: rtl/gpio_i2c_target.sv
module gpio_i2c_target
  import gpio_i2c_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b010000,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap_i,
  input  logic [BYTE_W-1:0] port_i,
  output logic              sda_oe_o,
  output logic              int_no
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
  st_e               state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, ptr_q, rdata_w;
  logic              rw_q, ack_q, oe_q;
  logic              byte_done, wr_w, ld_w, rd_in_w;

  gpio_i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  assign byte_done = scl_fall && cnt_q == LAST_BIT;
  assign wr_w      = state_q == ST_WDATA && byte_done;
  assign ld_w      = scl_fall && ((state_q == ST_ADDR_ACK && rw_q) ||
                                  (state_q == ST_RACK && ack_q));
  assign rd_in_w   = ld_w && ptr_q == '0;

  gpio_i2c_regs #(.DW(BYTE_W), .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .port_i (port_i),
    .ptr_i  (ptr_q),
    .wr_i   (wr_w),
    .wdata_i(sh_q),
    .rd_in_i(rd_in_w),
    .rdata_o(rdata_w),
    .int_no (int_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_w) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_w) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (ld_w) begin
      tx_q    <= rdata_w;
      oe_q    <= ~rdata_w[BYTE_W-1];
      cnt_q   <= 4'd1;
      state_q <= ST_RDATA;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == {ADDR_HI, addr_strap_i}) begin
                rw_q    <= sh_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IGNORE;
              end
            end else begin
              if (state_q == ST_PTR) ptr_q <= sh_q;
              oe_q    <= 1'b1;
              state_q <= (state_q == ST_PTR) ? ST_PTR_ACK : ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= (state_q == ST_ADDR_ACK) ? ST_PTR : ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (byte_done) begin
            oe_q    <= 1'b0;
            state_q <= ST_RACK;
          end else if (scl_fall) begin
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
            oe_q  <= ~tx_q[BYTE_W-2];
            cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) ack_q <= ~sda_s;
          else if (scl_fall) state_q <= ST_IGNORE;  // controller NACK
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/gpio_i2c_target_chk.sv
module gpio_i2c_target_chk
  import gpio_i2c_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       start_w,
  input logic       stop_w,
  input logic       sda_oe_o,
  input logic       int_no,
  input logic       rd_in_w,
  input st_e        state_q,
  input logic [3:0] cnt_q
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> ($past(!scl_s) || $past(start_w || stop_w))); // R9

  AST_RELEASE_ON_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w || stop_w) |=> !sda_oe_o); // R8

  AST_INT_CLEARS_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_in_w |=> int_no); // R7

  AST_QUIET_WHEN_UNADDRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !sda_oe_o); // R3

  AST_BITCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd8); // R8
endmodule

bind gpio_i2c_target gpio_i2c_target_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_s   (scl_s),
  .start_w (start_w),
  .stop_w  (stop_w),
  .sda_oe_o(sda_oe_o),
  .int_no  (int_no),
  .rd_in_w (rd_in_w),
  .state_q (state_q),
  .cnt_q   (cnt_q)
);

// File: tb/gpio_i2c_target_tb_top.sv
module gpio_i2c_target_tb_top;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [7:0] port = 8'h00;
  logic       sda_oe, int_n, sda_line;
  int         n_chk = 0, n_fail = 0, oe_bad = 0;
  logic [7:0] model [4];
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  gpio_i2c_target dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .addr_strap_i(strap),
    .port_i      (port),
    .sda_oe_o    (sda_oe),
    .int_no      (int_n)
  );

  always @(sda_oe) if (rst_n && scl) oe_bad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] p);
    if (p == 8'd0) return port;
    if (p < 8'd4)  return model[p[1:0]];
    return 8'h00;
  endfunction

  function automatic logic [7:0] dev(input logic rw);
    return {6'b010000, strap, rw};
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wq(Q); scl = 1'b1; wq(Q); s = sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, input bit upd, input logic [7:0] np,
                         output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    sda_m = ~mack; wq(Q); scl = 1'b1;
    if (upd) port = np;
    wq(2*Q); scl = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic reg_write(input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    wr_byte(dev(1'b0), a0); wr_byte(p, a1); wr_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
    if (p != 0 && p < 4) model[p[1:0]] = d;
  endtask

  task automatic reg_read(input logic [7:0] p, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    logic [7:0] e;
    bus_start();
    wr_byte(dev(1'b0), a0); wr_byte(p, a1);
    bus_start();
    wr_byte(dev(1'b1), a2);
    e = port;
    rd_byte(1'b0, 1'b0, 8'h00, d);
    if (p == 0) last_rd = e;
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic ok, a, b;
    logic [7:0] d, p, v, e;
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    wq(4);
    check(sda_oe == 1'b0, "R1 oe at reset", sda_oe, 0);
    check(int_n == 1'b1, "R1 int at reset", int_n, 1);
    rst_n = 1'b1;
    wq(10);

    // R2 R4 R5 basic write then read back
    reg_write(8'h01, 8'hA5, ok);
    check(ok, "R2 R4 acks on write", ok, 1);
    reg_read(8'h01, d, ok);
    check(ok && d == 8'hA5, "R5 read reg1", d, 8'hA5);

    // R3 wrong strap bit
    strap = 1'b1;
    bus_start();
    wr_byte({6'b010000, 1'b0, 1'b0}, a);
    check(!a, "R3 mismatched address nack", a, 0);
    wr_byte(8'h01, a);
    check(!a, "R3 following byte nack", a, 0);
    wr_byte(8'h11, a);
    bus_stop();
    reg_read(8'h01, d, ok);
    check(ok, "R2 strap=1 address acked", ok, 1);
    check(d == 8'hA5, "R3 reg1 untouched", d, 8'hA5);

    // R4 R5 out of range pointer
    reg_write(8'h07, 8'h3C, ok);
    check(ok, "R4 out of range acked", ok, 1);
    reg_read(8'h07, d, ok);
    check(ok && d == 8'h00, "R5 out of range reads zero", d, 0);

    // R4 R7 write to input port discarded, interrupt
    port = 8'h5A; wq(10);
    check(int_n == 1'b0, "R7 int asserts on change", int_n, 0);
    reg_write(8'h00, 8'h77, ok);
    bus_start();
    wr_byte(dev(1'b0), a); wr_byte(8'h00, a);
    bus_start();
    wr_byte(dev(1'b1), a);
    rd_byte(1'b0, 1'b0, 8'h00, d);
    last_rd = 8'h5A;
    wq(5);
    check(int_n == 1'b1, "R7 int clear before stop", int_n, 1);
    check(d == 8'h5A, "R4 input port write discarded", d, 8'h5A);
    bus_stop();

    // R5 R6 streaming with fresh samples, then NACK release
    port = 8'h11; wq(10);
    bus_start();
    wr_byte(dev(1'b1), a);
    check(a, "R4 pointer persists, read acked", a, 1);
    rd_byte(1'b1, 1'b1, 8'h22, d);
    check(d == 8'h11, "R5 stream byte 1", d, 8'h11);
    rd_byte(1'b1, 1'b1, 8'h33, d);
    check(d == 8'h22, "R5 stream byte 2", d, 8'h22);
    rd_byte(1'b0, 1'b0, 8'h00, d);
    check(d == 8'h33, "R6 stream byte 3", d, 8'h33);
    last_rd = 8'h33;
    rd_byte(1'b0, 1'b0, 8'h00, d);
    check(d == 8'hFF, "R6 released after NACK", d, 8'hFF);
    bus_stop();
    check(int_n == 1'b1, "R7 int high after stream", int_n, 1);

    // R4 pointer persists and does not advance
    reg_write(8'h02, 8'h81, ok);
    bus_start();
    wr_byte(dev(1'b1), a);
    rd_byte(1'b1, 1'b0, 8'h00, d);
    rd_byte(1'b0, 1'b0, 8'h00, v);
    bus_stop();
    check(a && d == 8'h81, "R4 bare read uses kept pointer", d, 8'h81);
    check(v == 8'h81, "R4 pointer not advanced", v, 8'h81);

    // R8 START mid-byte, then STOP mid data byte
    bus_start();
    clk_bit(1'b0, b); clk_bit(1'b1, b); clk_bit(1'b1, b);
    bus_start();
    wr_byte(dev(1'b0), a);
    check(a, "R8 restart mid-byte clears count", a, 1);
    wr_byte(8'h03, a); wr_byte(8'h4E, b);
    model[3] = 8'h4E;
    clk_bit(1'b1, b); clk_bit(1'b0, b); clk_bit(1'b1, b); clk_bit(1'b1, b);
    scl = 1'b0;
    bus_stop();
    reg_read(8'h03, d, ok);
    check(d == 8'h4E, "R8 partial byte discarded", d, 8'h4E);

    // random mix
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 12; k++) begin
      p = 8'($urandom_range(0, 7));
      v = 8'($urandom);
      reg_write(p, v, ok);
      check(ok, "R4 random write acked", ok, 1);
      port = 8'($urandom); wq(10);
      check(int_n == (port == last_rd), "R7 random int level", int_n, int'(port == last_rd));
      e = exp_reg(p);
      reg_read(p, d, ok);
      check(ok && d == e, "R5 random read", d, e);
    end

    check(oe_bad == 0, "R9 oe changed while SCL high", oe_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule